// File: doc/BRIEF.md
# Dual-clause MDIO management master

This block is a management-bus master for external PHYs. Host software programs a small register file and the block builds the serial frame, drives the management clock (MDC) and the bidirectional data line, and hands back the 16-bit result of a read. The clause is chosen per transaction through a start-type field in the configuration register. One controller can therefore run direct Clause 22 frames and Clause 45 sequences on the same pins. A Clause 45 sequence is an address frame followed by a write or a read.

Software writes the configuration, address and data registers, then writes an opcode to the operation register. It polls the busy flag until the flag clears. For a Clause 45 access, the register-address field holds the device (MMD) number. The 16-bit register address travels in the data register during the address frame.

Register map (word offsets on `reg_addr`):

| Offset | Register | Layout |
|---|---|---|
| 0 | Configuration | divider N in bits [DIV_W-1:0], start type in bit 8, preamble enable in bit 9 |
| 1 | Address | register/device address in bits [4:0], PHY address in bits [12:8] |
| 2 | Data | bits [15:0] |
| 3 | Operation | opcode in bits [1:0], busy flag in bit 8 (read only) |

Top module: `mdio_master`

## Requirements
- R1: After reset the busy flag (bit 8 of the operation register at offset 3) reads 0, `mdc` is low and `mdio_oe` is low.
- R2: While a frame runs, each MDC high phase and each MDC low phase lasts N+1 core clocks, where N is the configuration divider field (bits [DIV_W-1:0] of offset 0). MDC is low whenever busy is clear.
- R3: With the preamble bit set (bit 9 of offset 0), a frame begins with 32 driven ones and has 64 MDC rising edges in total. With the bit clear, the frame has exactly 32 rising edges.
- R4: With start type 1 (bit 8 of offset 0), opcode 1 sends a Clause 22 write frame. The frame is, MSB first: start 01, opcode 01, PHY address [12:8], register address [4:0], turnaround 10, then the 16 data-register bits, all driven.
- R5: With start type 1, opcode 2 sends start 01, opcode 10 and the two addresses. The master releases `mdio_oe` for the turnaround and all 16 data bits and samples `mdio_i` on MDC rising edges. Once busy clears, offset 2 reads the 16 sampled bits, first bit in bit 15.
- R6: With start type 0, opcode 0 sends a Clause 45 address frame. The frame is start 00, opcode 00, PHY address, device number from [4:0], turnaround 10, then the data register as the 16-bit payload.
- R7: With start type 0, opcode 1 sends a Clause 45 write frame (start 00, opcode 01, data driven). Opcode 3 sends a Clause 45 read frame (start 00, opcode 11), and its result reaches offset 2 as in R5.
- R8: Busy is set from the opcode write until after the last MDC rising edge of the frame. An opcode write made while busy is set starts no frame and leaves the stored opcode unchanged.
- R9: While the master drives the line, `mdio_o` changes only when MDC falls. `mdio_oe` is low whenever no frame is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word offset |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data of the register selected by reg_addr |
| mdio_i | input | 1 | Sampled management data line |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data driven value |
| mdio_oe | output | 1 | Management data output enable |

## Verification
The bench keeps the default divider width of 8. It reprograms the divider to 0, 1, 2 and 3 across tests, so both the shortest half period (one core clock) and longer ones are measured on the pins. Preamble on and off are both exercised, which places the frame fields at two different positions in the bit stream. A behavioural PHY answers reads on falling MDC edges, so the sampling point and the bit order of the captured value are both observed.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    localparam int ADR_W     = 5;
    localparam int DAT_W     = 16;
    localparam int PRE_LEN   = 32;
    localparam int FRAME_LEN = 32;
    localparam int VEC_LEN   = PRE_LEN + FRAME_LEN;
    localparam int IDX_W     = $clog2(VEC_LEN);
    localparam int HDR_LEN   = 14;

    localparam logic [1:0] OFS_CFG  = 2'd0;
    localparam logic [1:0] OFS_ADDR = 2'd1;
    localparam logic [1:0] OFS_DATA = 2'd2;
    localparam logic [1:0] OFS_OP   = 2'd3;

    localparam int CFG_ST_BIT  = 8;
    localparam int CFG_PRE_BIT = 9;
    localparam int OP_BUSY_BIT = 8;
    localparam int PHY_LSB     = 8;

    typedef struct packed {
        logic              pre_en;
        logic              st_c22;
        logic [1:0]        op;
        logic [ADR_W-1:0]  phy;
        logic [ADR_W-1:0]  rga;
        logic [DAT_W-1:0]  data;
    } mdio_req_t;
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             rise,
    output logic             fall
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             mdc;
    } div_t;

    div_t s_d, s_q;
    logic tick;

    always_comb begin
        s_d  = s_q;
        tick = run && (s_q.cnt == div);
        if (!run) begin
            s_d.cnt = '0;
            s_d.mdc = 1'b0;
        end else if (tick) begin
            s_d.cnt = '0;
            s_d.mdc = ~s_q.mdc;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign mdc  = s_q.mdc;
    assign rise = tick && !s_q.mdc;
    assign fall = tick && s_q.mdc;

    // R2: mid-phase the clock level holds
    p_half_period_r2: assert property (@(posedge clk) disable iff (!rst_n)
        run && $past(run) && (s_q.cnt != '0) |-> $stable(s_q.mdc));
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import mdio_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  mdio_req_t        req,
    input  logic             rise,
    input  logic             fall,
    input  logic             mdio_i,
    output logic             busy,
    output logic             mdio_o,
    output logic             mdio_oe,
    output logic             done,
    output logic             is_rd,
    output logic [DAT_W-1:0] rdata
);
    localparam logic [IDX_W-1:0] IDX_TA   = IDX_W'(PRE_LEN + HDR_LEN);
    localparam logic [IDX_W-1:0] IDX_DAT  = IDX_W'(PRE_LEN + HDR_LEN + 2);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(VEC_LEN - 1);
    localparam logic [IDX_W-1:0] IDX_NOPRE = IDX_W'(PRE_LEN);

    typedef struct packed {
        logic               busy;
        logic               rd;
        logic [IDX_W-1:0]   idx;
        logic [VEC_LEN-1:0] vec;
        logic [DAT_W-1:0]   cap;
    } eng_t;

    eng_t s_d, s_q;
    logic [FRAME_LEN-1:0] frame;

    always_comb begin
        s_d   = s_q;
        done  = 1'b0;
        frame = {1'b0, req.st_c22, req.op, req.phy, req.rga, 2'b10, req.data};
        if (start) begin
            s_d.busy = 1'b1;
            s_d.rd   = req.op[1];
            s_d.cap  = '0;
            if (req.pre_en) begin
                s_d.vec = {{PRE_LEN{1'b1}}, frame};
                s_d.idx = '0;
            end else begin
                s_d.vec = {frame, {PRE_LEN{1'b1}}};
                s_d.idx = IDX_NOPRE;
            end
        end else if (s_q.busy) begin
            if (rise && s_q.rd && (s_q.idx >= IDX_DAT))
                s_d.cap = {s_q.cap[DAT_W-2:0], mdio_i};
            if (fall) begin
                if (s_q.idx == IDX_LAST) begin
                    s_d.busy = 1'b0;
                    done     = 1'b1;
                end else begin
                    s_d.idx = s_q.idx + 1'b1;
                    s_d.vec = {s_q.vec[VEC_LEN-2:0], 1'b1};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy    = s_q.busy;
    assign is_rd   = s_q.rd;
    assign rdata   = s_q.cap;
    assign mdio_o  = s_q.busy ? s_q.vec[VEC_LEN-1] : 1'b1;
    assign mdio_oe = s_q.busy && !(s_q.rd && (s_q.idx >= IDX_TA));

    // R8: the register side never launches a frame over a running one
    p_start_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !s_q.busy);
    // R8: busy only ends on a falling clock strobe
    p_busy_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.busy && !fall |=> s_q.busy);
endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [1:0]  reg_addr,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    input  logic        mdio_i,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe
);
    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic             st_c22;
        logic             pre_en;
        logic [ADR_W-1:0] phy;
        logic [ADR_W-1:0] rga;
        logic [DAT_W-1:0] data;
        logic [1:0]       op;
    } regs_t;

    regs_t s_d, s_q;

    logic             busy, done, is_rd, start, rise, fall;
    logic [DAT_W-1:0] cap;
    mdio_req_t        req;

    assign start = reg_wr && (reg_addr == OFS_OP) && !busy;

    always_comb begin
        s_d = s_q;
        if (reg_wr) begin
            unique case (reg_addr)
                OFS_CFG: begin
                    s_d.div    = reg_wdata[DIV_W-1:0];
                    s_d.st_c22 = reg_wdata[CFG_ST_BIT];
                    s_d.pre_en = reg_wdata[CFG_PRE_BIT];
                end
                OFS_ADDR: begin
                    s_d.rga = reg_wdata[ADR_W-1:0];
                    s_d.phy = reg_wdata[PHY_LSB+ADR_W-1:PHY_LSB];
                end
                OFS_DATA: s_d.data = reg_wdata[DAT_W-1:0];
                OFS_OP:   if (!busy) s_d.op = reg_wdata[1:0];
                default: ;
            endcase
        end
        if (done && is_rd) s_d.data = cap;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        req.pre_en = s_q.pre_en;
        req.st_c22 = s_q.st_c22;
        req.op     = reg_wdata[1:0];
        req.phy    = s_q.phy;
        req.rga    = s_q.rga;
        req.data   = s_q.data;
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            OFS_CFG: begin
                reg_rdata[DIV_W-1:0]  = s_q.div;
                reg_rdata[CFG_ST_BIT]  = s_q.st_c22;
                reg_rdata[CFG_PRE_BIT] = s_q.pre_en;
            end
            OFS_ADDR: begin
                reg_rdata[ADR_W-1:0]                 = s_q.rga;
                reg_rdata[PHY_LSB+ADR_W-1:PHY_LSB]   = s_q.phy;
            end
            OFS_DATA: reg_rdata[DAT_W-1:0] = s_q.data;
            OFS_OP: begin
                reg_rdata[1:0]         = s_q.op;
                reg_rdata[OP_BUSY_BIT] = busy;
            end
            default: ;
        endcase
    end

    mdio_clk_div #(.DIV_W(DIV_W)) u_clk (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (busy),
        .div  (s_q.div),
        .mdc  (mdc),
        .rise (rise),
        .fall (fall)
    );

    mdio_frame_engine u_eng (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .req    (req),
        .rise   (rise),
        .fall   (fall),
        .mdio_i (mdio_i),
        .busy   (busy),
        .mdio_o (mdio_o),
        .mdio_oe(mdio_oe),
        .done   (done),
        .is_rd  (is_rd),
        .rdata  (cap)
    );

    // R2: clock parked low outside frames
    p_idle_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc);
    // R9: driven data moves only with a falling clock
    p_mdio_on_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) && mdio_oe && $past(mdio_oe) && !$stable(mdio_o)
        |-> $fell(mdc));
    // R5: once released inside a frame, the line stays released
    p_read_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !mdio_oe |=> !mdio_oe);
endmodule

// File: tb/mdio_master_bench.sv
module mdio_master_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = 16'd0;
    logic [15:0] reg_rdata;
    logic        mdio_i = 1'b1;
    logic        mdc, mdio_o, mdio_oe;

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    logic bits [0:127];
    logic oes  [0:127];
    int   nrise = 0;
    int   pre_len = 0;
    logic [15:0] phy_pat = 16'h0000;
    time  t_r0, t_r1;
    int   viol = 0;
    logic prev_o = 1'b1, prev_oe = 1'b0, prev_mdc = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mdio_master u_mdio_master (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdio_i(mdio_i),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
    );

    always @(posedge mdc) begin
        if (nrise < 128) begin
            bits[nrise] = mdio_o;
            oes[nrise]  = mdio_oe;
        end
        if (nrise == 0) t_r0 = $time;
        if (nrise == 1) t_r1 = $time;
        nrise = nrise + 1;
    end

    // behavioural PHY: presents the next read bit after each falling edge
    always @(negedge mdc) begin
        int nxt;
        nxt = nrise - pre_len;
        if (nxt >= 16 && nxt <= 31) mdio_i <= phy_pat[31-nxt];
        else                        mdio_i <= 1'b1;
    end

    always @(negedge clk) begin
        if (mdio_oe && prev_oe && (mdio_o != prev_o) && !(prev_mdc && !mdc))
            viol = viol + 1;
        prev_o = mdio_o; prev_oe = mdio_oe; prev_mdc = mdc;
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(logic [1:0] a, logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [15:0] v;
        for (int i = 0; i < 20000; i++) begin
            reg_read(2'd3, v);
            if (!v[8]) break;
        end
    endtask

    task automatic setup(bit pre, bit c22, int dv, logic [4:0] phy,
                         logic [4:0] rga, logic [15:0] dat);
        reg_write(2'd0, {6'd0, pre, c22, 8'(dv)});
        reg_write(2'd1, {3'd0, phy, 3'd0, rga});
        reg_write(2'd2, dat);
        nrise = 0;
        pre_len = pre ? 32 : 0;
    endtask

    function automatic logic [31:0] rec_frame();
        logic [31:0] r;
        for (int i = 0; i < 32; i++) r[31-i] = bits[pre_len+i];
        return r;
    endfunction

    function automatic logic [31:0] exp_frame(bit c22, logic [1:0] op,
        logic [4:0] phy, logic [4:0] rga, logic [15:0] dat);
        return {1'b0, c22, op, phy, rga, 2'b10, dat};
    endfunction

    task automatic t_reset();
        logic [15:0] v;
        reg_read(2'd3, v);
        check("R1 busy after reset", 32'(v[8]), 32'd0);
        check("R1 mdc after reset", 32'(mdc), 32'd0);
        check("R1 oe after reset", 32'(mdio_oe), 32'd0);
    endtask

    task automatic t_c22_write();
        logic [31:0] pre_ok;
        setup(1, 1, 1, 5'h13, 5'h0A, 16'hA5C3);
        reg_write(2'd3, 16'd1);
        wait_idle();
        check("R3 rise count with preamble", 32'(nrise), 32'd64);
        pre_ok = 32'd1;
        for (int i = 0; i < 32; i++) if (bits[i] !== 1'b1 || oes[i] !== 1'b1) pre_ok = 0;
        check("R3 preamble ones driven", pre_ok, 32'd1);
        check("R4 c22 write frame", rec_frame(), exp_frame(1, 2'b01, 5'h13, 5'h0A, 16'hA5C3));
        check("R2 mdc period div=1", 32'(t_r1 - t_r0), 32'(4*CLK_PERIOD));
        check("R9 change on fall only", 32'(viol), 32'd0);
        check("R9 released when idle", 32'(mdio_oe), 32'd0);
        check("R2 mdc low when idle", 32'(mdc), 32'd0);
    endtask

    task automatic t_c22_read();
        logic [15:0] v;
        logic [31:0] r, e, oe_ok;
        setup(0, 1, 2, 5'h01, 5'h1F, 16'h0000);
        phy_pat = 16'h9B61;
        reg_write(2'd3, 16'd2);
        wait_idle();
        check("R3 rise count without preamble", 32'(nrise), 32'd32);
        r = rec_frame(); e = exp_frame(1, 2'b10, 5'h01, 5'h1F, 16'h0);
        check("R5 c22 read header", {18'd0, r[31:18]}, {18'd0, e[31:18]});
        oe_ok = 1;
        for (int i = 0; i < 14; i++) if (oes[i] !== 1'b1) oe_ok = 0;
        for (int i = 14; i < 32; i++) if (oes[i] !== 1'b0) oe_ok = 0;
        check("R5 release for turnaround and data", oe_ok, 32'd1);
        reg_read(2'd2, v);
        check("R5 captured read data", 32'(v), 32'h9B61);
        check("R2 mdc period div=2", 32'(t_r1 - t_r0), 32'(6*CLK_PERIOD));
    endtask

    task automatic t_c45();
        logic [15:0] v;
        logic [31:0] r, e;
        setup(1, 0, 0, 5'h05, 5'h03, 16'h1234);
        reg_write(2'd3, 16'd0);
        wait_idle();
        check("R6 c45 address frame", rec_frame(), exp_frame(0, 2'b00, 5'h05, 5'h03, 16'h1234));
        check("R2 mdc period div=0", 32'(t_r1 - t_r0), 32'(2*CLK_PERIOD));
        reg_write(2'd2, 16'hBEEF);
        nrise = 0;
        reg_write(2'd3, 16'd1);
        wait_idle();
        check("R7 c45 write frame", rec_frame(), exp_frame(0, 2'b01, 5'h05, 5'h03, 16'hBEEF));
        phy_pat = 16'h4C2D;
        nrise = 0;
        reg_write(2'd3, 16'd3);
        wait_idle();
        r = rec_frame(); e = exp_frame(0, 2'b11, 5'h05, 5'h03, 16'h0);
        check("R7 c45 read header", {18'd0, r[31:18]}, {18'd0, e[31:18]});
        reg_read(2'd2, v);
        check("R7 c45 read data", 32'(v), 32'h4C2D);
        check("R9 change on fall only c45", 32'(viol), 32'd0);
    endtask

    task automatic t_busy();
        logic [15:0] v;
        setup(0, 1, 3, 5'h1E, 5'h11, 16'h0F0F);
        reg_write(2'd3, 16'd1);
        reg_read(2'd3, v);
        check("R8 busy after start", 32'(v[8]), 32'd1);
        reg_write(2'd3, 16'd2);
        reg_read(2'd3, v);
        check("R8 opcode kept while busy", 32'(v[1:0]), 32'd1);
        while (nrise < 32) @(negedge clk);
        reg_read(2'd3, v);
        check("R8 busy at last rising edge", 32'(v[8]), 32'd1);
        wait_idle();
        repeat (40) @(negedge clk);
        check("R8 ignored op starts no frame", 32'(nrise), 32'd32);
        check("R8 frame unaffected", rec_frame(), exp_frame(1, 2'b01, 5'h1E, 5'h11, 16'h0F0F));
        reg_read(2'd2, v);
        check("R8 data unchanged", 32'(v), 32'h0F0F);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_c22_write();
        t_c22_read();
        t_c45();
        t_busy();
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD*150000);
        if (!finished) begin
            tests++; fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule